// File: doc/BRIEF.md
# Sample Capture Peripheral with Memory Write Master

This block sits on a processor's memory-mapped bus and moves converter results into system memory without processor involvement. Software programs a sample count and a destination address, then sets a start bit. From then on every rising edge of the board's busy line causes one strobed parallel read from the converter board. Each 16-bit result enters a small buffer and is written out as a 32-bit word by the block's own write master, which respects the memory side's waitrequest.

Results normally land at consecutive words. A control bit instead sends every result to one fixed address, which suits a memory-mapped sink. Status flags report completion, a sample lost because the buffer was full, and a write by software to the read-only status word. A separate device-write word lets software push a 16-bit value to a 5-bit board register address over the same parallel bus. The bus is modelled as split input, output and output-enable signals. A soft reset returns the core to its reset state and pulses the board reset line.

Top module: `acq_dma_periph`

## Requirements
- R1: The slave address is 3 bits wide with these offsets: 0 control, 1 sample count, 2 base address, 3 status (read only), 4 device write (write only). `s_readdata` is valid one cycle after `s_read`. Control reads back only bit 2. Count and base read back as written. Offset 4 reads as zero.
- R2: Writing control with bit 0 set starts a capture of `count` samples. Each rising edge of `busy_i` during a capture gives exactly one read, with `rd_n` low for one cycle and `brd_addr` = 0x10. The value on `bus_data_i` is taken as the sample.
- R3: Sample i (counting from 0) is written as `{16'h0000, sample}` to address base + 4*i, with `m_byteenable` = 4'hF.
- R4: While control bit 2 is set, every sample of a capture is written to the base address.
- R5: While `m_waitrequest` is high, the write master holds `m_write`, `m_address` and `m_writedata` steady. No sample is lost or repeated because of a stall.
- R6: Status bit 0 (done) is set once the last sample of a capture has been accepted by memory. A start clears it. A start with count 0 completes at once.
- R7: The buffer holds 8 samples plus one in the master's holding register. With memory stalled, the tenth sample of a capture is dropped and sets status bit 1 (overflow). That bit stays set until the next start or soft reset.
- R8: A write to offset 3 sets status bit 2 and leaves the other status bits unchanged. The bit stays set until the next start or soft reset.
- R9: Writing control with bit 3 set drives `wr_n` low for exactly 2 cycles. During those cycles `bus_oe` is high, `bus_data_o` equals device-write bits [15:0] and `brd_addr` equals device-write bits [20:16]. Device-write bits [31:21] are ignored. `bus_oe` is low whenever `wr_n` is high, and `rd_n` and `wr_n` are never low together.
- R10: `brd_reset` is high under `rst`. Writing control with bit 1 set clears all registers and status and raises `brd_reset` for exactly one cycle.
- R11: A rising edge of `busy_i` while no capture is running, or after the count is used up, produces no read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_address | input | 3 | Slave word address |
| s_write | input | 1 | Slave write request |
| s_read | input | 1 | Slave read request |
| s_writedata | input | 32 | Slave write data |
| s_readdata | output | 32 | Slave read data, one cycle after the read |
| m_waitrequest | input | 1 | Memory stall |
| m_address | output | 32 | Master byte address |
| m_write | output | 1 | Master write request |
| m_byteenable | output | 4 | Master byte enables |
| m_writedata | output | 32 | Master write data |
| bus_data_i | input | 16 | Parallel bus, value driven by the board |
| bus_data_o | output | 16 | Parallel bus, value driven by this block |
| bus_oe | output | 1 | Output enable of the parallel bus |
| busy_i | input | 1 | Board result-ready line; a rising edge marks a new sample |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| brd_addr | output | 5 | Board register address |
| brd_reset | output | 1 | Board reset |

## Verification
The bench builds the block with its default parameters: an 8-entry buffer, a 2-cycle board write and read address 0x10. The small buffer means that holding waitrequest high across ten busy edges reaches the overflow case, including the extra slot in the master's holding register. A repeating waitrequest pattern, with two stalled cycles out of three, exercises the hold rule on every transfer. The normal and same-address addressing modes and the board write all run against a queue-based model of the expected memory traffic.

// File: rtl/acq_pkg.sv
package acq_pkg;
  localparam logic [2:0] OFS_CTRL = 3'd0;
  localparam logic [2:0] OFS_CNT  = 3'd1;
  localparam logic [2:0] OFS_BASE = 3'd2;
  localparam logic [2:0] OFS_STAT = 3'd3;
  localparam logic [2:0] OFS_DEV  = 3'd4;

  localparam int CTL_START = 0;
  localparam int CTL_SRST  = 1;
  localparam int CTL_SAME  = 2;
  localparam int CTL_BWR   = 3;

  typedef enum logic [1:0] {PORT_IDLE, PORT_RD, PORT_WR} port_state_t;
endpackage

// File: rtl/sample_fifo.sv
module sample_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          empty,
  output logic          full
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;

  always_ff @(posedge clk)
    if (push) mem[wp] <= din;

  always_ff @(posedge clk) begin
    if (clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + (AW+1)'(push) - (AW+1)'(pop);
    end
  end

  assign dout  = mem[rp];
  assign empty = (cnt == '0);
  assign full  = (cnt == (AW+1)'(DEPTH));

  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (clr) cnt <= (AW+1)'(DEPTH)); // R7
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (clr) pop |-> !empty); // R5
  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (clr) push |-> !full); // R7
endmodule

// File: rtl/board_port.sv
module board_port
  import acq_pkg::*;
#(
  parameter int          DW      = 16,
  parameter int          BAW     = 5,
  parameter logic [4:0]  RD_ADDR = 5'h10,
  parameter int          WR_CYC  = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           busy_i,
  input  logic           rd_allow,
  input  logic           wr_go,
  input  logic [BAW-1:0] wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic [DW-1:0]  bus_data_i,
  output logic           rd_launch,
  output logic           port_quiet,
  output logic           smp_valid,
  output logic [DW-1:0]  smp_data,
  output logic           rd_n,
  output logic           wr_n,
  output logic           bus_oe,
  output logic [DW-1:0]  bus_data_o,
  output logic [BAW-1:0] brd_addr
);
  localparam int CW = $clog2(WR_CYC + 1);

  port_state_t state;
  logic busy_r, busy_r2, rise, rd_req, wr_pend;
  logic [CW-1:0] wcnt;

  assign rise       = busy_r & ~busy_r2;
  assign rd_launch  = (state == PORT_IDLE) && rd_req && rd_allow;
  assign port_quiet = !rd_req && (state != PORT_RD) && !smp_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_r     <= 1'b0;
      busy_r2    <= 1'b0;
      state      <= PORT_IDLE;
      rd_req     <= 1'b0;
      wr_pend    <= 1'b0;
      wcnt       <= '0;
      smp_valid  <= 1'b0;
      smp_data   <= '0;
      rd_n       <= 1'b1;
      wr_n       <= 1'b1;
      bus_oe     <= 1'b0;
      bus_data_o <= '0;
      brd_addr   <= '0;
    end else begin
      busy_r    <= busy_i;
      busy_r2   <= busy_r;
      smp_valid <= 1'b0;
      if (wr_go) wr_pend <= 1'b1;
      case (state)
        PORT_IDLE: begin
          if (rd_req) begin
            rd_req <= 1'b0;
            if (rd_allow) begin
              state    <= PORT_RD;
              rd_n     <= 1'b0;
              brd_addr <= BAW'(RD_ADDR);
            end
          end else if (wr_pend) begin
            wr_pend    <= 1'b0;
            state      <= PORT_WR;
            wr_n       <= 1'b0;
            bus_oe     <= 1'b1;
            bus_data_o <= wr_data;
            brd_addr   <= wr_addr;
            wcnt       <= '0;
          end
        end
        PORT_RD: begin
          smp_valid <= 1'b1;
          smp_data  <= bus_data_i;
          rd_n      <= 1'b1;
          state     <= PORT_IDLE;
        end
        default: begin
          if (wcnt == CW'(WR_CYC - 1)) begin
            wr_n   <= 1'b1;
            bus_oe <= 1'b0;
            state  <= PORT_IDLE;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
      endcase
      if (rise && rd_allow) rd_req <= 1'b1;
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst) !(!rd_n && !wr_n)); // R9
  AST_WR_DRIVES: assert property (@(posedge clk) disable iff (rst) !wr_n |-> bus_oe); // R9
  AST_OE_ONLY_WR: assert property (@(posedge clk) disable iff (rst) wr_n |-> !bus_oe); // R9
  AST_WR_TWO: assert property (@(posedge clk) disable iff (rst) $fell(wr_n) |=> !wr_n); // R9
  AST_RD_ONE: assert property (@(posedge clk) disable iff (rst) !rd_n |=> rd_n); // R2
endmodule

// File: rtl/dma_writer.sv
module dma_writer #(
  parameter int AW = 32,
  parameter int MW = 32,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_base,
  input  logic [AW-1:0] base,
  input  logic          same_addr,
  input  logic          fifo_empty,
  input  logic [SW-1:0] fifo_dout,
  output logic          fifo_pop,
  output logic          busy,
  input  logic          m_waitrequest,
  output logic [AW-1:0] m_address,
  output logic          m_write,
  output logic [MW/8-1:0] m_byteenable,
  output logic [MW-1:0] m_writedata
);
  logic [AW-1:0] cur;

  assign fifo_pop     = !m_write && !fifo_empty;
  assign busy         = m_write;
  assign m_byteenable = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur         <= '0;
      m_write     <= 1'b0;
      m_address   <= '0;
      m_writedata <= '0;
    end else begin
      if (load_base) cur <= base;
      if (m_write && !m_waitrequest) begin
        m_write <= 1'b0;
        if (!same_addr && !load_base) cur <= cur + AW'(MW / 8);
      end else if (fifo_pop) begin
        m_write     <= 1'b1;
        m_address   <= cur;
        m_writedata <= {{(MW-SW){1'b0}}, fifo_dout};
      end
    end
  end

  AST_MW_HOLD: assert property (@(posedge clk) disable iff (rst)
    (m_write && m_waitrequest) |=> (m_write && $stable(m_address) && $stable(m_writedata))); // R5
  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (rst)
    (m_write && !m_waitrequest) |=> !m_write); // R5
endmodule

// File: rtl/acq_dma_periph.sv
module acq_dma_periph
  import acq_pkg::*;
#(
  parameter int         SAW        = 3,
  parameter int         DW         = 32,
  parameter int         SW         = 16,
  parameter int         BAW        = 5,
  parameter int         FIFO_DEPTH = 8,
  parameter logic [4:0] RD_ADDR    = 5'h10,
  parameter int         WR_CYC     = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [SAW-1:0] s_address,
  input  logic           s_write,
  input  logic           s_read,
  input  logic [DW-1:0]  s_writedata,
  output logic [DW-1:0]  s_readdata,
  input  logic           m_waitrequest,
  output logic [DW-1:0]  m_address,
  output logic           m_write,
  output logic [DW/8-1:0] m_byteenable,
  output logic [DW-1:0]  m_writedata,
  input  logic [SW-1:0]  bus_data_i,
  output logic [SW-1:0]  bus_data_o,
  output logic           bus_oe,
  input  logic           busy_i,
  output logic           rd_n,
  output logic           wr_n,
  output logic [BAW-1:0] brd_addr,
  output logic           brd_reset
);
  localparam int DEVW = SW + BAW;

  logic soft_q, core_rst;
  logic [DW-1:0] cnt_reg, base_reg, rd_left;
  logic [DEVW-1:0] dev_reg;
  logic same_mode, active, done, ovf, roerr;
  logic wr_ctrl, start, wr_go, rd_allow, rd_launch, port_quiet;
  logic smp_valid, fifo_empty, fifo_full, fifo_pop, wr_busy, finished;
  logic [SW-1:0] smp_data, fifo_dout;

  assign core_rst = rst | soft_q;
  assign wr_ctrl  = s_write && (s_address == SAW'(OFS_CTRL));
  assign start    = wr_ctrl && s_writedata[CTL_START];
  assign wr_go    = wr_ctrl && s_writedata[CTL_BWR];
  assign rd_allow = active && (rd_left != '0);
  assign finished = active && (rd_left == '0) && port_quiet && fifo_empty && !wr_busy;

  always_ff @(posedge clk) begin
    if (rst) soft_q <= 1'b0;
    else     soft_q <= wr_ctrl && s_writedata[CTL_SRST];
    brd_reset <= core_rst;
  end

  always_ff @(posedge clk) begin
    if (core_rst) begin
      cnt_reg <= '0; base_reg <= '0; dev_reg <= '0; rd_left <= '0;
      same_mode <= 1'b0; active <= 1'b0; done <= 1'b0; ovf <= 1'b0; roerr <= 1'b0;
    end else begin
      if (wr_ctrl) same_mode <= s_writedata[CTL_SAME];
      if (s_write && s_address == SAW'(OFS_CNT))  cnt_reg  <= s_writedata;
      if (s_write && s_address == SAW'(OFS_BASE)) base_reg <= s_writedata;
      if (s_write && s_address == SAW'(OFS_DEV))  dev_reg  <= s_writedata[DEVW-1:0];
      if (s_write && s_address == SAW'(OFS_STAT)) roerr    <= 1'b1;
      if (start) begin
        active <= 1'b1; rd_left <= cnt_reg;
        done <= 1'b0; ovf <= 1'b0; roerr <= 1'b0;
      end else begin
        if (rd_launch) rd_left <= rd_left - 1'b1;
        if (smp_valid && fifo_full) ovf <= 1'b1;
        if (finished) begin
          active <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) s_readdata <= '0;
    else if (s_read) begin
      case (s_address)
        SAW'(OFS_CTRL): s_readdata <= DW'({same_mode, 2'b00});
        SAW'(OFS_CNT):  s_readdata <= cnt_reg;
        SAW'(OFS_BASE): s_readdata <= base_reg;
        SAW'(OFS_STAT): s_readdata <= DW'({roerr, ovf, done});
        default:        s_readdata <= '0;
      endcase
    end
  end

  board_port #(.DW(SW), .BAW(BAW), .RD_ADDR(RD_ADDR), .WR_CYC(WR_CYC)) port_i (
    .clk(clk), .rst(core_rst), .busy_i(busy_i), .rd_allow(rd_allow), .wr_go(wr_go),
    .wr_addr(dev_reg[DEVW-1:SW]), .wr_data(dev_reg[SW-1:0]), .bus_data_i(bus_data_i),
    .rd_launch(rd_launch), .port_quiet(port_quiet), .smp_valid(smp_valid), .smp_data(smp_data),
    .rd_n(rd_n), .wr_n(wr_n), .bus_oe(bus_oe), .bus_data_o(bus_data_o), .brd_addr(brd_addr));

  sample_fifo #(.DW(SW), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk(clk), .clr(core_rst | start), .push(smp_valid && !fifo_full), .din(smp_data),
    .pop(fifo_pop), .dout(fifo_dout), .empty(fifo_empty), .full(fifo_full));

  dma_writer #(.AW(DW), .MW(DW), .SW(SW)) wr_i (
    .clk(clk), .rst(core_rst), .load_base(start), .base(base_reg), .same_addr(same_mode),
    .fifo_empty(fifo_empty), .fifo_dout(fifo_dout), .fifo_pop(fifo_pop), .busy(wr_busy),
    .m_waitrequest(m_waitrequest), .m_address(m_address), .m_write(m_write),
    .m_byteenable(m_byteenable), .m_writedata(m_writedata));

  AST_NO_READ_IDLE: assert property (@(posedge clk) disable iff (core_rst) !rd_allow |=> rd_n); // R11
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (core_rst) (ovf && !start) |=> ovf); // R7
  AST_ROERR_SET: assert property (@(posedge clk) disable iff (core_rst)
    (s_write && s_address == SAW'(OFS_STAT)) |=> roerr); // R8
  AST_DONE_CLR: assert property (@(posedge clk) disable iff (core_rst) start |=> !done); // R6
  AST_BRD_RST: assert property (@(posedge clk) rst |=> brd_reset); // R10
endmodule

// File: tb/acq_dma_periph_tb.sv
module acq_dma_periph_tb_top;
  logic clk = 0, rst = 1;
  logic [2:0] s_address = 0;
  logic s_write = 0, s_read = 0;
  logic [31:0] s_writedata = 0, s_readdata;
  logic m_waitrequest = 0;
  logic [31:0] m_address, m_writedata;
  logic m_write;
  logic [3:0] m_byteenable;
  logic [15:0] bus_data_i = 0, bus_data_o;
  logic bus_oe, busy_i = 0, rd_n, wr_n, brd_reset;
  logic [4:0] brd_addr;

  int tests = 0, fails = 0, cyc = 0, wmode = 0;
  int rd_lows = 0, wr_lows = 0, rst_highs = 0;
  bit finished = 0;
  logic [63:0] expq[$];
  logic [15:0] exp_bdata = 0;
  logic [4:0]  exp_baddr = 0;

  acq_dma_periph dut_i (.*);

  always #5 clk = ~clk;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    m_waitrequest <= (wmode == 2) ? 1'b1 : (wmode == 1) ? (cyc % 3 != 2) : 1'b0;
  end

  // per-clock comparison against the expected memory traffic and strobe rules
  always @(negedge clk) if (!rst) begin
    if (m_write && !m_waitrequest) begin
      if (expq.size() == 0) chk(0, "R3", "unexpected write addr", m_address, 0);
      else begin
        logic [63:0] e;
        e = expq.pop_front();
        chk(m_address == e[63:32], "R3", "write address", m_address, e[63:32]);
        chk(m_writedata == e[31:0], "R3", "write data", m_writedata, e[31:0]);
        chk(m_byteenable == 4'hF, "R3", "byte enables", {28'b0, m_byteenable}, 32'hF);
      end
    end
    if (!rd_n) rd_lows++;
    if (brd_reset) rst_highs++;
    if (!wr_n) begin
      wr_lows++;
      chk(bus_oe && bus_data_o == exp_bdata && brd_addr == exp_baddr, "R9", "board write drive",
          {bus_oe, brd_addr, bus_data_o}, {1'b1, exp_baddr, exp_bdata});
    end else if (bus_oe) chk(0, "R9", "bus driven outside write", 1, 0);
  end

  always @(posedge clk) if (cyc > 100000 && !finished) begin
    finished = 1;
    fails++;
    $display("FAIL watchdog: actual %0d expected below 100000", cyc);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic wreg(logic [2:0] a, logic [31:0] d);
    @(negedge clk); s_address = a; s_writedata = d; s_write = 1;
    @(negedge clk); s_write = 0;
  endtask

  task automatic rreg(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); s_address = a; s_read = 1;
    @(negedge clk); s_read = 0; d = s_readdata;
  endtask

  task automatic pulse(logic [15:0] v);
    bus_data_i = v; busy_i = 1;
    repeat (6) @(negedge clk);
    busy_i = 0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    chk(brd_reset && rd_n && wr_n && !bus_oe && !m_write, "R10", "reset outputs",
        {brd_reset, rd_n, wr_n, bus_oe, m_write}, 5'b11100);
    rst = 0;
    repeat (3) @(negedge clk);
    rreg(3'd3, d); chk(d == 0, "R1", "status after reset", d, 0);

    // register map
    wreg(3'd1, 5); wreg(3'd2, 32'h1000); wreg(3'd0, 4);
    rreg(3'd1, d); chk(d == 5, "R1", "count readback", d, 5);
    rreg(3'd2, d); chk(d == 32'h1000, "R1", "base readback", d, 32'h1000);
    rreg(3'd0, d); chk(d == 4, "R1", "control readback", d, 4);
    wreg(3'd4, 32'h1234); rreg(3'd4, d); chk(d == 0, "R1", "device word reads zero", d, 0);
    wreg(3'd0, 0);

    // idle busy edges
    rd_lows = 0; pulse(16'h1111);
    chk(rd_lows == 0, "R11", "read while idle", rd_lows, 0);

    // normal capture with periodic stall
    wmode = 1; rd_lows = 0;
    wreg(3'd0, 1);
    rreg(3'd3, d); chk(d[0] == 0, "R6", "done cleared by start", d, 0);
    for (int i = 0; i < 5; i++) begin
      expq.push_back({32'h1000 + 4 * i, 16'h0, 16'hA000 + 16'(i * 7)});
      pulse(16'hA000 + 16'(i * 7));
    end
    repeat (30) @(negedge clk);
    chk(rd_lows == 5, "R2", "one read per busy edge", rd_lows, 5);
    chk(expq.size() == 0, "R5", "all stalled writes delivered", expq.size(), 0);
    rreg(3'd3, d); chk(d == 1, "R6", "done after capture", d, 1);
    rd_lows = 0; pulse(16'h2222);
    chk(rd_lows == 0, "R11", "read after count used", rd_lows, 0);

    // same-address mode
    wreg(3'd1, 3); wreg(3'd2, 32'h2000); wreg(3'd0, 5);
    for (int i = 0; i < 3; i++) begin
      expq.push_back({32'h2000, 16'h0, 16'h5500 + 16'(i)});
      pulse(16'h5500 + 16'(i));
    end
    repeat (30) @(negedge clk);
    chk(expq.size() == 0, "R4", "same address writes", expq.size(), 0);
    rreg(3'd3, d); chk(d == 1, "R4", "same mode done", d, 1);
    wreg(3'd0, 0);

    // overflow under full stall
    wmode = 2; repeat (2) @(negedge clk);
    wreg(3'd1, 10); wreg(3'd2, 32'h3000); wreg(3'd0, 1);
    for (int i = 0; i < 10; i++) begin
      if (i < 9) expq.push_back({32'h3000 + 4 * i, 16'h0, 16'hC000 + 16'(i)});
      pulse(16'hC000 + 16'(i));
    end
    rreg(3'd3, d); chk(d == 2, "R7", "overflow while stalled", d, 2);
    wmode = 0; repeat (40) @(negedge clk);
    chk(expq.size() == 0, "R7", "nine samples kept", expq.size(), 0);
    rreg(3'd3, d); chk(d == 3, "R7", "overflow sticky with done", d, 3);
    wreg(3'd1, 0); wreg(3'd0, 1); repeat (3) @(negedge clk);
    rreg(3'd3, d); chk(d == 1, "R7", "start clears overflow, zero count done", d, 1);

    // read-only write
    wreg(3'd3, 32'hFFFF_FFFF);
    rreg(3'd3, d); chk(d == 5, "R8", "status write flag", d, 5);

    // soft reset
    wreg(3'd1, 7); wreg(3'd0, 4); rst_highs = 0;
    wreg(3'd0, 2); repeat (4) @(negedge clk);
    chk(rst_highs == 1, "R10", "board reset pulse", rst_highs, 1);
    rreg(3'd3, d); chk(d == 0, "R10", "status cleared", d, 0);
    rreg(3'd1, d); chk(d == 0, "R10", "count cleared", d, 0);
    rreg(3'd0, d); chk(d == 0, "R10", "mode cleared", d, 0);

    // board write; upper bits ignored
    exp_bdata = 16'hABCD; exp_baddr = 5'h05; wr_lows = 0;
    wreg(3'd4, 32'hFFE5_ABCD); wreg(3'd0, 8);
    repeat (10) @(negedge clk);
    chk(wr_lows == 2, "R9", "write strobe length", wr_lows, 2);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule